// File: doc/BRIEF.md
# Memory Line Authentication Tracker

This block sits between an encrypted external memory and a processor pipeline. Every line that arrives from memory comes with four cipher blocks, four precomputed keystream pads and a stored message authentication code (MAC). On arrival the line receives a sequential tag and is parked in an in-order queue until a separate MAC engine presents the code it computed for the oldest parked line. A match retires that line and reports its tag. A mismatch marks the memory as tampered. The tamper state is sticky until reset and shuts down all further traffic.

Decryption is a plain XOR of each cipher block with its pad, so plaintext is ready long before authentication ends. A two-bit policy input sets what happens while any authentication is outstanding. It can hold back new external fetches, hold back external writes, hold back the release of decrypted data until that line's own tag is verified, or apply all three. Holding back fetches or data release stops a tampered pointer from leaking a secret through the address of a speculative fetch.

Top module: `mlat_tracker`

## Requirements
- R1: After reset `line_ready` is 1, and `pending`, `tamper_flag`, `dec_valid` and `vfy_valid` are 0, and `oldest_tag` is 0.
- R2: The first line accepted after reset gets tag 0. Each later accepted line gets the previous tag plus one, modulo 16, so tag 15 is followed by tag 0.
- R3: Plaintext block k is cipher block k XOR pad block k. Block k occupies bits [32k+31:32k] of the 128-bit line.
- R4: Under policy 2'b00 (fetch hold) or 2'b01 (write hold), an accepted line appears on `dec_valid`/`dec_tag`/`dec_addr`/`dec_plain` in the cycle after acceptance.
- R5: Under policy 2'b10 (issue hold) or 2'b11 (hold everything), a line's plaintext appears only in the cycle after that line is verified, together with its `vfy_valid`. In policy 2'b10, fetches and writes are granted even while lines are pending.
- R6: When `mac_valid` is high and `mac_value` equals the stored MAC of the oldest pending line, that line is removed and `vfy_valid` pulses with its tag in the next cycle. Lines retire in arrival order. A `mac_valid` with nothing pending has no effect.
- R7: Under policy 2'b00, `fetch_grant` stays 0 while any line is pending and follows `fetch_req` otherwise. Writes are not held.
- R8: Under policy 2'b01, `write_grant` stays 0 while any line is pending and follows `write_req` otherwise. Fetches are not held.
- R9: Under policy 2'b11, fetches, writes and data release are all held while any line is pending.
- R10: At most 8 lines are pending. With 8 pending, `line_ready` is 0 and an offered line is not taken and consumes no tag.
- R11: `cfg_mode` is taken only while nothing is pending. A change while lines are pending has no effect until the queue drains.
- R12: A MAC mismatch on the oldest line sets `tamper_flag` in the next cycle, with that line's tag on `tamper_tag` and its address on `tamper_addr`. The flag holds until reset. While it is set, `line_ready`, `fetch_grant` and `write_grant` are 0, no data is released, and `mac_valid` is ignored.
- R13: `oldest_tag` shows the tag of the oldest pending line. When nothing is pending, it shows the tag the next line will receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Hold policy: 00 fetch, 01 write, 10 issue, 11 all |
| line_valid | input | 1 | An encrypted line is offered |
| line_ready | output | 1 | Queue can take a line |
| line_addr | input | 32 | Address of the offered line |
| line_cipher | input | 128 | Four cipher blocks |
| line_pad | input | 128 | Four decryption pads |
| line_mac | input | 32 | MAC stored with the line |
| mac_valid | input | 1 | Computed MAC for the oldest line is present |
| mac_value | input | 32 | Computed MAC |
| fetch_req | input | 1 | Pipeline wants an external fetch |
| fetch_grant | output | 1 | External fetch may launch |
| write_req | input | 1 | Pipeline wants an external write |
| write_grant | output | 1 | External write may proceed |
| dec_valid | output | 1 | Decrypted line released |
| dec_tag | output | 4 | Tag of released line |
| dec_addr | output | 32 | Address of released line |
| dec_plain | output | 128 | Plaintext of released line |
| vfy_valid | output | 1 | A line was verified |
| vfy_tag | output | 4 | Tag of the verified line |
| pending | output | 1 | At least one line awaits verification |
| oldest_tag | output | 4 | Oldest pending tag, or next tag when none pend |
| tamper_flag | output | 1 | Sticky MAC mismatch indication |
| tamper_tag | output | 4 | Tag of the failing line |
| tamper_addr | output | 32 | Address of the failing line |

## Verification
The assertions assume the MAC engine presents codes only for the oldest pending line and in order. They also assume the memory side never offers a line while `line_ready` is low, except in deliberate probes of the full case. The stimulus follows this: it keeps its own list of pending lines and always answers for the front of that list. It offers a line to a full queue only once, to show the offer is refused. The deliberate mismatch comes last, so the sticky tamper state does not cut short the other scenarios.

// File: rtl/mlat_pkg.sv
package mlat_pkg;

    typedef enum logic [1:0] {
        HOLD_FETCH = 2'b00,
        HOLD_WRITE = 2'b01,
        HOLD_ISSUE = 2'b10,
        HOLD_ALL   = 2'b11
    } hold_mode_e;

    function automatic logic holds_fetch(input logic [1:0] mode);
        return (mode == HOLD_FETCH) || (mode == HOLD_ALL);
    endfunction

    function automatic logic holds_write(input logic [1:0] mode);
        return (mode == HOLD_WRITE) || (mode == HOLD_ALL);
    endfunction

    function automatic logic holds_issue(input logic [1:0] mode);
        return (mode == HOLD_ISSUE) || (mode == HOLD_ALL);
    endfunction

endpackage

// File: rtl/mlat_decrypt.sv
module mlat_decrypt #(
    parameter int NBLK  = 4,
    parameter int BLK_W = 32,
    localparam int LINE_W = NBLK * BLK_W
) (
    input  logic [LINE_W-1:0] cipher,
    input  logic [LINE_W-1:0] pad,
    output logic [LINE_W-1:0] plain
);
    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        assign plain[k*BLK_W +: BLK_W] = cipher[k*BLK_W +: BLK_W] ^ pad[k*BLK_W +: BLK_W];
    end
endmodule

// File: rtl/mlat_fifo.sv
module mlat_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head_data,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptrs_t;

    ptrs_t p_d, p_q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] ptr);
        return (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    endfunction

    always_comb begin
        p_d = p_q;
        if (push) p_d.wr = step(p_q.wr);
        if (pop)  p_d.rd = step(p_q.rd);
        case ({push, pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[p_q.wr] <= push_data;
    end

    assign head_data = mem[p_q.rd];
    assign count     = p_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (p_q.cnt != CNT_W'(DEPTH))); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (p_q.cnt != '0)); // R6
endmodule

// File: rtl/mlat_gate.sv
module mlat_gate
    import mlat_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       busy,
    input  logic       tamper,
    input  logic       fetch_req,
    input  logic       write_req,
    output logic       fetch_grant,
    output logic       write_grant
);
    always_comb begin
        fetch_grant = fetch_req && !tamper && !(busy && holds_fetch(mode));
        write_grant = write_req && !tamper && !(busy && holds_write(mode));
    end
endmodule

// File: rtl/mlat_tracker.sv
module mlat_tracker
    import mlat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BLK_W  = 32,
    parameter int NBLK   = 4,
    parameter int MAC_W  = 32,
    parameter int TAG_W  = 4,
    parameter int DEPTH  = 8,
    localparam int LINE_W = NBLK * BLK_W,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              line_valid,
    output logic              line_ready,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic [LINE_W-1:0] line_cipher,
    input  logic [LINE_W-1:0] line_pad,
    input  logic [MAC_W-1:0]  line_mac,
    input  logic              mac_valid,
    input  logic [MAC_W-1:0]  mac_value,
    input  logic              fetch_req,
    output logic              fetch_grant,
    input  logic              write_req,
    output logic              write_grant,
    output logic              dec_valid,
    output logic [TAG_W-1:0]  dec_tag,
    output logic [ADDR_W-1:0] dec_addr,
    output logic [LINE_W-1:0] dec_plain,
    output logic              vfy_valid,
    output logic [TAG_W-1:0]  vfy_tag,
    output logic              pending,
    output logic [TAG_W-1:0]  oldest_tag,
    output logic              tamper_flag,
    output logic [TAG_W-1:0]  tamper_tag,
    output logic [ADDR_W-1:0] tamper_addr
);
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic [MAC_W-1:0]  mac;
        logic [LINE_W-1:0] cipher;
        logic [LINE_W-1:0] pad;
    } entry_t;
    localparam int ENTRY_W = $bits(entry_t);

    typedef struct packed {
        logic [TAG_W-1:0]  next_tag;
        logic [1:0]        mode;
        logic              tamper;
        logic [TAG_W-1:0]  tamper_tag;
        logic [ADDR_W-1:0] tamper_addr;
        logic              dec_valid;
        logic [TAG_W-1:0]  dec_tag;
        logic [ADDR_W-1:0] dec_addr;
        logic [LINE_W-1:0] dec_plain;
        logic              vfy_valid;
        logic [TAG_W-1:0]  vfy_tag;
    } state_t;

    state_t st_d, st_q;
    entry_t head, incoming;
    logic [ENTRY_W-1:0] head_raw;
    logic [CNT_W-1:0]   cnt;
    logic [LINE_W-1:0]  in_plain, head_plain;
    logic [1:0]         eff_mode;
    logic busy, accept, judge, match, mismatch;

    mlat_decrypt #(.NBLK(NBLK), .BLK_W(BLK_W)) u_dec_in (
        .cipher(line_cipher), .pad(line_pad), .plain(in_plain));
    mlat_decrypt #(.NBLK(NBLK), .BLK_W(BLK_W)) u_dec_head (
        .cipher(head.cipher), .pad(head.pad), .plain(head_plain));

    assign incoming = '{tag: st_q.next_tag, addr: line_addr, mac: line_mac,
                        cipher: line_cipher, pad: line_pad};
    assign head = entry_t'(head_raw);

    mlat_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .push_data(incoming),
        .pop(match), .head_data(head_raw), .count(cnt));

    always_comb begin
        busy       = (cnt != '0);
        eff_mode   = busy ? st_q.mode : cfg_mode;
        line_ready = !st_q.tamper && (cnt != CNT_W'(DEPTH));
        accept     = line_valid && line_ready;
        judge      = mac_valid && busy && !st_q.tamper;
        match      = judge && (mac_value == head.mac);
        mismatch   = judge && (mac_value != head.mac);

        st_d           = st_q;
        st_d.dec_valid = 1'b0;
        st_d.vfy_valid = 1'b0;
        if (!busy) st_d.mode = cfg_mode;
        if (accept) st_d.next_tag = st_q.next_tag + 1'b1;
        if (mismatch) begin
            st_d.tamper      = 1'b1;
            st_d.tamper_tag  = head.tag;
            st_d.tamper_addr = head.addr;
        end
        if (match) begin
            st_d.vfy_valid = 1'b1;
            st_d.vfy_tag   = head.tag;
        end
        if (accept && !holds_issue(eff_mode) && !mismatch) begin
            st_d.dec_valid = 1'b1;
            st_d.dec_tag   = st_q.next_tag;
            st_d.dec_addr  = line_addr;
            st_d.dec_plain = in_plain;
        end else if (match && holds_issue(eff_mode)) begin
            st_d.dec_valid = 1'b1;
            st_d.dec_tag   = head.tag;
            st_d.dec_addr  = head.addr;
            st_d.dec_plain = head_plain;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mlat_gate u_gate (
        .mode(eff_mode), .busy(busy), .tamper(st_q.tamper),
        .fetch_req(fetch_req), .write_req(write_req),
        .fetch_grant(fetch_grant), .write_grant(write_grant));

    assign pending     = busy;
    assign oldest_tag  = busy ? head.tag : st_q.next_tag;
    assign dec_valid   = st_q.dec_valid;
    assign dec_tag     = st_q.dec_tag;
    assign dec_addr    = st_q.dec_addr;
    assign dec_plain   = st_q.dec_plain;
    assign vfy_valid   = st_q.vfy_valid;
    assign vfy_tag     = st_q.vfy_tag;
    assign tamper_flag = st_q.tamper;
    assign tamper_tag  = st_q.tamper_tag;
    assign tamper_addr = st_q.tamper_addr;

    AST_TAMPER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tamper |=> st_q.tamper); // R12
    AST_TAMPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tamper |-> (!fetch_grant && !write_grant && !line_ready)); // R12
    AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && holds_fetch(st_q.mode)) |-> !fetch_grant); // R7
    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && holds_write(st_q.mode)) |-> !write_grant); // R8
    AST_ISSUE_AFTER_VFY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dec_valid && holds_issue(st_q.mode)) |-> (st_q.vfy_valid && st_q.dec_tag == st_q.vfy_tag)); // R5
    AST_VFY_IS_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vfy_valid |-> (st_q.vfy_tag == $past(oldest_tag))); // R6
endmodule

// File: tb/mlat_tracker_tb_top.sv
module mlat_tracker_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n;
    logic [1:0]   cfg_mode;
    logic         line_valid, line_ready;
    logic [31:0]  line_addr;
    logic [127:0] line_cipher, line_pad;
    logic [31:0]  line_mac;
    logic         mac_valid;
    logic [31:0]  mac_value;
    logic         fetch_req, fetch_grant, write_req, write_grant;
    logic         dec_valid;
    logic [3:0]   dec_tag;
    logic [31:0]  dec_addr;
    logic [127:0] dec_plain;
    logic         vfy_valid;
    logic [3:0]   vfy_tag;
    logic         pending;
    logic [3:0]   oldest_tag;
    logic         tamper_flag;
    logic [3:0]   tamper_tag;
    logic [31:0]  tamper_addr;

    mlat_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .line_valid(line_valid), .line_ready(line_ready), .line_addr(line_addr),
        .line_cipher(line_cipher), .line_pad(line_pad), .line_mac(line_mac),
        .mac_valid(mac_valid), .mac_value(mac_value),
        .fetch_req(fetch_req), .fetch_grant(fetch_grant),
        .write_req(write_req), .write_grant(write_grant),
        .dec_valid(dec_valid), .dec_tag(dec_tag), .dec_addr(dec_addr), .dec_plain(dec_plain),
        .vfy_valid(vfy_valid), .vfy_tag(vfy_tag), .pending(pending), .oldest_tag(oldest_tag),
        .tamper_flag(tamper_flag), .tamper_tag(tamper_tag), .tamper_addr(tamper_addr));

    typedef struct {
        logic [3:0]   tag;
        logic [31:0]  addr;
        logic [127:0] plain;
        logic [31:0]  mac;
    } item_t;

    item_t      dec_q[$];
    item_t      pend_q[$];
    logic [3:0] vfy_q[$];
    item_t      mon_e;
    logic [3:0] mon_t;
    int         checks = 0;
    int         errors = 0;
    logic [3:0] exp_tag = 4'd0;
    bit         issue_mode = 1'b0;
    bit         done = 1'b0;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(input int i, input logic [31:0] salt);
        return {32'(i) * 32'h9e3779b1 ^ salt, 32'(i) + 32'h0f0f1234, salt + 32'(i * 7), ~salt ^ 32'(i)};
    endfunction

    task automatic send_line(input int i);
        item_t it;
        @(negedge clk);
        chk("R10 ready before offer", line_ready, 1);
        line_valid  = 1'b1;
        line_addr   = 32'h1000_0000 + 32'(i * 64);
        line_cipher = mk(i, 32'hc0de_0000);
        line_pad    = mk(i, 32'h5a5a_a5a5);
        line_mac    = 32'hfeed_0000 + 32'(i * 13);
        it.tag   = exp_tag;
        it.addr  = line_addr;
        it.plain = line_cipher ^ line_pad;
        it.mac   = line_mac;
        pend_q.push_back(it);
        if (!issue_mode) dec_q.push_back(it);
        exp_tag = exp_tag + 4'd1;
        @(negedge clk);
        line_valid = 1'b0;
    endtask

    task automatic verify_next(input bit good);
        item_t it;
        @(negedge clk);
        it = pend_q.pop_front();
        mac_valid = 1'b1;
        mac_value = good ? it.mac : ~it.mac;
        if (good) begin
            vfy_q.push_back(it.tag);
            if (issue_mode) dec_q.push_back(it);
        end
        @(negedge clk);
        mac_valid = 1'b0;
    endtask

    // Scoreboard monitor: compares released and verified lines against queues
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (dec_valid) begin
                if (dec_q.size() == 0) begin
                    chk("R5 release with no line due", dec_tag, 4'hx);
                end else begin
                    mon_e = dec_q.pop_front();
                    chk("R2 dec tag", dec_tag, mon_e.tag);
                    chk("R4 dec addr", dec_addr, mon_e.addr);
                    chk("R3 dec plaintext", dec_plain, mon_e.plain);
                end
            end
            if (vfy_valid) begin
                if (vfy_q.size() == 0) begin
                    chk("R6 unexpected verify", vfy_tag, 4'hx);
                end else begin
                    mon_t = vfy_q.pop_front();
                    chk("R6 verify order", vfy_tag, mon_t);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all reqs): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_mode = 2'b00; line_valid = 1'b0; line_addr = '0;
        line_cipher = '0; line_pad = '0; line_mac = '0; mac_valid = 1'b0;
        mac_value = '0; fetch_req = 1'b0; write_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 line_ready", line_ready, 1);
        chk("R1 pending", pending, 0);
        chk("R1 tamper", tamper_flag, 0);
        chk("R1 dec_valid", dec_valid, 0);
        chk("R1 vfy_valid", vfy_valid, 0);
        chk("R13 oldest after reset", oldest_tag, 0);

        // Fetch hold (00)
        for (int i = 0; i < 3; i++) send_line(i);
        @(negedge clk);
        fetch_req = 1'b1; write_req = 1'b1;
        cfg_mode = 2'b01; // R11 change while busy must not apply
        #1;
        chk("R7 fetch held", fetch_grant, 0);
        chk("R7 write free", write_grant, 1);
        chk("R11 old mode kept", fetch_grant, 0);
        chk("R13 oldest tag", oldest_tag, 0);
        verify_next(1'b1);
        #1 chk("R13 oldest after retire", oldest_tag, 1);
        verify_next(1'b1);
        verify_next(1'b1);
        #1;
        chk("R6 queue drained", pending, 0);
        chk("R13 next tag when empty", oldest_tag, 3);
        chk("R11 new mode after drain fetch", fetch_grant, 1);

        // Write hold (01)
        for (int i = 3; i < 5; i++) send_line(i);
        @(negedge clk); #1;
        chk("R8 write held", write_grant, 0);
        chk("R8 fetch free", fetch_grant, 1);
        verify_next(1'b1);
        verify_next(1'b1);
        #1 chk("R8 write resumes", write_grant, 1);

        // Issue hold (10)
        cfg_mode = 2'b10; issue_mode = 1'b1;
        for (int i = 5; i < 7; i++) send_line(i);
        repeat (3) @(negedge clk);
        #1;
        chk("R5 fetch free in issue", fetch_grant, 1);
        chk("R5 write free in issue", write_grant, 1);
        chk("R5 nothing released yet", dec_q.size(), 0);
        verify_next(1'b1);
        verify_next(1'b1);

        // Hold everything (11), fill to depth
        cfg_mode = 2'b11;
        for (int i = 7; i < 15; i++) send_line(i);
        @(negedge clk); #1;
        chk("R10 full not ready", line_ready, 0);
        chk("R9 fetch held", fetch_grant, 0);
        chk("R9 write held", write_grant, 0);
        @(negedge clk);
        line_valid = 1'b1; line_addr = 32'hdead_0000; // refused offer
        @(negedge clk);
        line_valid = 1'b0;
        for (int i = 0; i < 8; i++) verify_next(1'b1);
        #1 chk("R10 refused offer left nothing", pending, 0);

        // Idle MAC, then tag wrap in fetch hold
        @(negedge clk);
        mac_valid = 1'b1; mac_value = 32'h1234_5678;
        @(negedge clk);
        mac_valid = 1'b0;
        cfg_mode = 2'b00; issue_mode = 1'b0;
        send_line(15);
        send_line(16);
        #1 chk("R2 wrap oldest", oldest_tag, 15);
        verify_next(1'b1);
        verify_next(1'b1);

        // Tamper
        send_line(17);
        verify_next(1'b0);
        #1;
        chk("R12 tamper flag", tamper_flag, 1);
        chk("R12 tamper tag", tamper_tag, 1);
        chk("R12 tamper addr", tamper_addr, 32'h1000_0000 + 32'(17 * 64));
        chk("R12 not ready", line_ready, 0);
        chk("R12 fetch blocked", fetch_grant, 0);
        chk("R12 write blocked", write_grant, 0);
        @(negedge clk);
        mac_valid = 1'b1; mac_value = 32'hfeed_0000 + 32'(17 * 13);
        @(negedge clk);
        mac_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R12 flag sticky", tamper_flag, 1);
        chk("R12 line not retired", pending, 1);

        chk("R5 all releases seen", dec_q.size(), 0);
        chk("R6 all verifies seen", vfy_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule